// File: doc/BRIEF.md
# SMBus Host Register File

This block is the register file that software uses to drive an SMBus host controller. It sits on a plain byte-wide register bus with one-cycle reads. It holds the target address, the command byte, two data bytes, a block data port and a mode byte, and it passes all of them to a separate transaction engine. It also holds the control and status registers that govern that engine. The serial bus logic is not part of this block.

Software first reads the status register to claim ownership. A status read that finds the in-use semaphore clear sets it, so only one agent can see it clear. Software then clears any old flags, loads the parameters and writes the control register with the go bit set. The engine receives a one-cycle start pulse and runs the transfer. It reports completion, errors and finished block bytes as one-cycle events, and this block turns those events into sticky status flags. During a block transfer, each finished byte sets the byte-done flag, and that flag holds the engine until software clears it. A kill bit aborts a running transfer. The error check, receive address and slave data offsets are reserved and read as zero.

Top module: `smbh_regfile`

## Requirements
- R1: After synchronous reset every register is zero: status reads 0x00, and eng_start, eng_kill, eng_hold and irq are low.
- R2: Register offsets are: 0 status, 2 control, 3 command, 4 target address, 5 data0, 6 data1, 7 block data, 0xC mode (only bit 0 is stored). Offsets 1, 8 to 0xB and 0xD to 0xF read 0 and ignore writes. Read data is valid on the cycle after the read strobe.
- R3: Status bit 6 is the in-use semaphore. A status read that finds it 0 returns 0 in that bit and sets it. The bit stays set until software writes status with bit 6 = 1.
- R4: Status flag bits 1, 2, 3, 4, 6 and 7 are cleared by writing 1 to them. Writing 0 to a flag bit leaves it unchanged. Bit 0 is read-only and bit 5 reads 0.
- R5: Control bit 6 is go, bits 4:2 are the protocol, bit 1 is kill and bit 0 is the interrupt enable. A control write with go = 1 while the host is idle does three things: it stores the protocol and enable, it raises eng_start for exactly the next cycle, and it sets busy (status bit 0) from that cycle on. Control reads return {3'b000, protocol, 1'b0, enable}, so go and kill always read 0.
- R6: A control write with go = 1 and kill = 0 while busy is 1 is ignored. It produces no start pulse and leaves the protocol and enable unchanged.
- R7: A control write with kill = 1 raises eng_kill for the next cycle and clears busy. If busy was set, it also sets the failed flag (status bit 4). The other fields of that write are ignored.
- R8: While busy, an eng_done event sets status bit 1, eng_err[0] sets bit 2 and eng_err[1] sets bit 3. Busy clears at the same clock edge.
- R9: eng_done, eng_err and eng_byte have no effect while busy is 0.
- R10: While busy, eng_byte sets byte done (status bit 7). eng_hold follows that bit, so it stays high until software writes status with bit 7 = 1.
- R11: irq is high one cycle after the enable is 1 and any of status bits 1, 2, 3, 4 or 7 is set. It falls one cycle after that condition ends.
- R12: eng_i2c is high only when mode bit 0 is 1 and the stored protocol is 3'b101 (block).
- R13: An engine write with eng_wr_sel 0, 1 or 2 loads eng_wr_data into data0, data1 or the block port respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register offset |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, one cycle after reg_rd |
| eng_done | input | 1 | Engine completion event |
| eng_err | input | 2 | Engine error events (device, bus) |
| eng_byte | input | 1 | Engine finished one block byte |
| eng_wr | input | 1 | Engine writes a data register |
| eng_wr_sel | input | 2 | Target of the engine write: 0 data0, 1 data1, 2 block |
| eng_wr_data | input | DATA_W | Engine write data |
| eng_start | output | 1 | One-cycle start pulse |
| eng_kill | output | 1 | One-cycle abort pulse |
| eng_proto | output | 3 | Stored protocol selection |
| eng_i2c | output | 1 | I2C framing for block transfers |
| eng_cmd | output | DATA_W | Command byte |
| eng_tgt | output | DATA_W | Target address byte |
| eng_d0 | output | DATA_W | Data byte 0 |
| eng_d1 | output | DATA_W | Data byte 1 |
| eng_blk | output | DATA_W | Block data port |
| eng_hold | output | 1 | Engine must stall: byte done is pending |
| irq | output | 1 | Interrupt request |

## Verification
The bench's corner cases target these failure modes:
- A wrong semaphore would return 1 on the first status read after a release, or would never let the bit go.
- A design that accepts go while busy would emit a second start pulse and overwrite the running protocol.
- A faulty kill would leave busy high or raise the failed flag when nothing was running.
- Engine events that arrive while idle, and a byte-done flag held over several cycles and then released with a single-bit clear, expose designs that fail to gate events on busy or that let eng_hold drop early.

// File: rtl/smbh_pkg.sv
package smbh_pkg;
  localparam logic [3:0] OFS_STAT = 4'h0;
  localparam logic [3:0] OFS_CTL  = 4'h2;
  localparam logic [3:0] OFS_CMD  = 4'h3;
  localparam logic [3:0] OFS_TGT  = 4'h4;
  localparam logic [3:0] OFS_D0   = 4'h5;
  localparam logic [3:0] OFS_D1   = 4'h6;
  localparam logic [3:0] OFS_BLK  = 4'h7;
  localparam logic [3:0] OFS_MODE = 4'hC;

  localparam int N_ERR     = 2;
  localparam int SB_BUSY   = 0;
  localparam int SB_DONE   = 1;
  localparam int SB_ERR0   = 2;
  localparam int SB_FAIL   = 4;
  localparam int SB_OWN    = 6;
  localparam int SB_BYTE   = 7;

  localparam int CB_IEN    = 0;
  localparam int CB_KILL   = 1;
  localparam int CB_PLO    = 2;
  localparam int CB_PHI    = 4;
  localparam int CB_GO     = 6;

  localparam logic [2:0] PROTO_BLOCK = 3'b101;

  typedef enum logic [1:0] {
    ESEL_D0  = 2'd0,
    ESEL_D1  = 2'd1,
    ESEL_BLK = 2'd2,
    ESEL_NA  = 2'd3
  } esel_t;
endpackage

// File: rtl/smbh_ctrl.sv
module smbh_ctrl (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic       go_bit,
  input  logic       kill_bit,
  input  logic [2:0] proto_in,
  input  logic       ien_in,
  input  logic       end_evt,
  output logic       busy,
  output logic       start_p,
  output logic       kill_p,
  output logic       abort_evt,
  output logic [2:0] proto,
  output logic       ien
);
  logic accept;

  always_comb begin
    accept    = wr_en & ~kill_bit & ~(go_bit & busy);
    abort_evt = wr_en & kill_bit & busy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      start_p <= 1'b0;
      kill_p  <= 1'b0;
      proto   <= '0;
      ien     <= 1'b0;
    end else begin
      start_p <= accept & go_bit;
      kill_p  <= wr_en & kill_bit;
      if (accept) begin
        proto <= proto_in;
        ien   <= ien_in;
      end
      if ((wr_en & kill_bit) | end_evt)
        busy <= 1'b0;
      else if (accept & go_bit)
        busy <= 1'b1;
    end
  end
endmodule

// File: rtl/smbh_status.sv
module smbh_status
  import smbh_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_hit,
  input  logic             wr_hit,
  input  logic             clr_done,
  input  logic [N_ERR-1:0] clr_err,
  input  logic             clr_fail,
  input  logic             clr_own,
  input  logic             clr_byte,
  input  logic             busy,
  input  logic             done_evt,
  input  logic [N_ERR-1:0] err_evt,
  input  logic             abort_evt,
  input  logic             byte_evt,
  output logic [7:0]       value,
  output logic             pend,
  output logic             hold
);
  logic             done_q;
  logic [N_ERR-1:0] err_q;
  logic             fail_q;
  logic             own_q;
  logic             byte_q;

  for (genvar gi = 0; gi < N_ERR; gi++) begin : g_err
    always_ff @(posedge clk) begin
      if (rst)                           err_q[gi] <= 1'b0;
      else if (err_evt[gi])              err_q[gi] <= 1'b1;
      else if (wr_hit && clr_err[gi])    err_q[gi] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
      fail_q <= 1'b0;
      own_q  <= 1'b0;
      byte_q <= 1'b0;
    end else begin
      if (done_evt)                done_q <= 1'b1;
      else if (wr_hit && clr_done) done_q <= 1'b0;
      if (abort_evt)               fail_q <= 1'b1;
      else if (wr_hit && clr_fail) fail_q <= 1'b0;
      if (byte_evt)                byte_q <= 1'b1;
      else if (wr_hit && clr_byte) byte_q <= 1'b0;
      if (rd_hit && !own_q)        own_q  <= 1'b1;
      else if (wr_hit && clr_own)  own_q  <= 1'b0;
    end
  end

  always_comb begin
    value                        = '0;
    value[SB_BUSY]               = busy;
    value[SB_DONE]               = done_q;
    value[SB_ERR0 +: N_ERR]      = err_q;
    value[SB_FAIL]               = fail_q;
    value[SB_OWN]                = own_q;
    value[SB_BYTE]               = byte_q;
    pend = done_q | (|err_q) | fail_q | byte_q;
    hold = byte_q;
  end
endmodule

// File: rtl/smbh_params.sv
module smbh_params
  import smbh_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              eng_we,
  input  logic [1:0]        eng_sel,
  input  logic [DATA_W-1:0] eng_data,
  output logic [DATA_W-1:0] cmd,
  output logic [DATA_W-1:0] tgt,
  output logic [DATA_W-1:0] d0,
  output logic [DATA_W-1:0] d1,
  output logic [DATA_W-1:0] blk,
  output logic              mode_i2c
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cmd      <= '0;
      tgt      <= '0;
      d0       <= '0;
      d1       <= '0;
      blk      <= '0;
      mode_i2c <= 1'b0;
    end else begin
      if (wr_en) begin
        if (addr == ADDR_W'(OFS_CMD))  cmd      <= wdata;
        if (addr == ADDR_W'(OFS_TGT))  tgt      <= wdata;
        if (addr == ADDR_W'(OFS_D0))   d0       <= wdata;
        if (addr == ADDR_W'(OFS_D1))   d1       <= wdata;
        if (addr == ADDR_W'(OFS_BLK))  blk      <= wdata;
        if (addr == ADDR_W'(OFS_MODE)) mode_i2c <= wdata[0];
      end
      if (eng_we) begin
        case (esel_t'(eng_sel))
          ESEL_D0:  d0  <= eng_data;
          ESEL_D1:  d1  <= eng_data;
          ESEL_BLK: blk <= eng_data;
          default:  ;
        endcase
      end
    end
  end
endmodule

// File: rtl/smbh_regfile.sv
module smbh_regfile
  import smbh_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              eng_done,
  input  logic [1:0]        eng_err,
  input  logic              eng_byte,
  input  logic              eng_wr,
  input  logic [1:0]        eng_wr_sel,
  input  logic [DATA_W-1:0] eng_wr_data,
  output logic              eng_start,
  output logic              eng_kill,
  output logic [2:0]        eng_proto,
  output logic              eng_i2c,
  output logic [DATA_W-1:0] eng_cmd,
  output logic [DATA_W-1:0] eng_tgt,
  output logic [DATA_W-1:0] eng_d0,
  output logic [DATA_W-1:0] eng_d1,
  output logic [DATA_W-1:0] eng_blk,
  output logic              eng_hold,
  output logic              irq
);
  localparam int CTL_W = 8;

  logic             host_busy;
  logic             ctl_ien;
  logic             abort_evt;
  logic             st_pend;
  logic             mode_i2c;
  logic [7:0]       st_val;
  logic [CTL_W-1:0] ctl_val;
  logic             wr_ctl, wr_stat, rd_stat;
  logic             done_evt, byte_evt;
  logic [N_ERR-1:0] err_evt;

  always_comb begin
    wr_ctl   = reg_wr & (reg_addr == ADDR_W'(OFS_CTL));
    wr_stat  = reg_wr & (reg_addr == ADDR_W'(OFS_STAT));
    rd_stat  = reg_rd & (reg_addr == ADDR_W'(OFS_STAT));
    done_evt = eng_done & host_busy;
    err_evt  = eng_err & {N_ERR{host_busy}};
    byte_evt = eng_byte & host_busy;
    ctl_val  = '0;
    ctl_val[CB_PHI:CB_PLO] = eng_proto;
    ctl_val[CB_IEN]        = ctl_ien;
    eng_i2c  = mode_i2c & (eng_proto == PROTO_BLOCK);
  end

  smbh_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_ctl),
    .go_bit    (reg_wdata[CB_GO]),
    .kill_bit  (reg_wdata[CB_KILL]),
    .proto_in  (reg_wdata[CB_PHI:CB_PLO]),
    .ien_in    (reg_wdata[CB_IEN]),
    .end_evt   (done_evt | (|err_evt)),
    .busy      (host_busy),
    .start_p   (eng_start),
    .kill_p    (eng_kill),
    .abort_evt (abort_evt),
    .proto     (eng_proto),
    .ien       (ctl_ien)
  );

  smbh_status u_status (
    .clk       (clk),
    .rst       (rst),
    .rd_hit    (rd_stat),
    .wr_hit    (wr_stat),
    .clr_done  (reg_wdata[SB_DONE]),
    .clr_err   (reg_wdata[SB_ERR0 +: N_ERR]),
    .clr_fail  (reg_wdata[SB_FAIL]),
    .clr_own   (reg_wdata[SB_OWN]),
    .clr_byte  (reg_wdata[SB_BYTE]),
    .busy      (host_busy),
    .done_evt  (done_evt),
    .err_evt   (err_evt),
    .abort_evt (abort_evt),
    .byte_evt  (byte_evt),
    .value     (st_val),
    .pend      (st_pend),
    .hold      (eng_hold)
  );

  smbh_params #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_params (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .eng_we   (eng_wr),
    .eng_sel  (eng_wr_sel),
    .eng_data (eng_wr_data),
    .cmd      (eng_cmd),
    .tgt      (eng_tgt),
    .d0       (eng_d0),
    .d1       (eng_d1),
    .blk      (eng_blk),
    .mode_i2c (mode_i2c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      irq <= ctl_ien & st_pend;
      if (reg_rd) begin
        case (reg_addr)
          ADDR_W'(OFS_STAT): reg_rdata <= DATA_W'(st_val);
          ADDR_W'(OFS_CTL):  reg_rdata <= DATA_W'(ctl_val);
          ADDR_W'(OFS_CMD):  reg_rdata <= eng_cmd;
          ADDR_W'(OFS_TGT):  reg_rdata <= eng_tgt;
          ADDR_W'(OFS_D0):   reg_rdata <= eng_d0;
          ADDR_W'(OFS_D1):   reg_rdata <= eng_d1;
          ADDR_W'(OFS_BLK):  reg_rdata <= eng_blk;
          ADDR_W'(OFS_MODE): reg_rdata <= DATA_W'(mode_i2c);
          default:           reg_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/smbh_regfile_chk.sv
module smbh_regfile_chk
  import smbh_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              eng_done,
  input logic              eng_byte,
  input logic              eng_start,
  input logic              eng_kill,
  input logic              eng_hold,
  input logic              irq,
  input logic              busy,
  input logic              ien,
  input logic [7:0]        status
);
  logic ctl_w;
  assign ctl_w = reg_wr && (reg_addr == ADDR_W'(OFS_CTL));

  // R5
  a_r5_go_starts: assert property (@(posedge clk) disable iff (rst)
    (ctl_w && reg_wdata[CB_GO] && !reg_wdata[CB_KILL] && !busy) |=> (eng_start && busy));

  // R6
  a_r6_go_ignored: assert property (@(posedge clk) disable iff (rst)
    (ctl_w && reg_wdata[CB_GO] && !reg_wdata[CB_KILL] && busy) |=> !eng_start);

  // R7
  a_r7_kill_idles: assert property (@(posedge clk) disable iff (rst)
    (ctl_w && reg_wdata[CB_KILL]) |=> (eng_kill && !busy));

  // R3
  a_r3_claim: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == ADDR_W'(OFS_STAT) && !status[SB_OWN]) |=> status[SB_OWN]);

  // R8
  a_r8_done_ends: assert property (@(posedge clk) disable iff (rst)
    (eng_done && busy) |=> (!busy && status[SB_DONE]));

  // R10
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (eng_byte && busy) |=> eng_hold);

  // R11
  a_r11_irq_enabled: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(ien));
endmodule

bind smbh_regfile smbh_regfile_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .eng_done  (eng_done),
  .eng_byte  (eng_byte),
  .eng_start (eng_start),
  .eng_kill  (eng_kill),
  .eng_hold  (eng_hold),
  .irq       (irq),
  .busy      (host_busy),
  .ien       (ctl_ien),
  .status    (st_val)
);

// File: tb/test_smbh_regfile.sv
`timescale 1ns/1ps
module test_smbh_regfile;
  localparam int DW = 8;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          eng_done = 1'b0, eng_byte = 1'b0, eng_wr = 1'b0;
  logic [1:0]    eng_err = '0, eng_wr_sel = '0;
  logic [DW-1:0] eng_wr_data = '0;
  logic          eng_start, eng_kill, eng_i2c, eng_hold, irq;
  logic [2:0]    eng_proto;
  logic [DW-1:0] eng_cmd, eng_tgt, eng_d0, eng_d1, eng_blk;

  always #2.5 clk = ~clk;

  smbh_regfile #(.DATA_W(DW), .ADDR_W(AW)) i_smbh_regfile (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_done(eng_done), .eng_err(eng_err),
    .eng_byte(eng_byte), .eng_wr(eng_wr), .eng_wr_sel(eng_wr_sel), .eng_wr_data(eng_wr_data),
    .eng_start(eng_start), .eng_kill(eng_kill), .eng_proto(eng_proto), .eng_i2c(eng_i2c),
    .eng_cmd(eng_cmd), .eng_tgt(eng_tgt), .eng_d0(eng_d0), .eng_d1(eng_d1), .eng_blk(eng_blk),
    .eng_hold(eng_hold), .irq(irq)
  );

  int n_tot = 0;
  int n_bad = 0;
  logic [DW-1:0] exp_q[$];
  string         tag_q[$];
  logic          rd_pend = 1'b0;
  bit            own_m = 1'b0;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_tot++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: compares read data the cycle after each read strobe
  always @(posedge clk) rd_pend <= reg_rd & ~rst;
  always @(negedge clk) begin
    if (rd_pend) begin
      if (exp_q.size() == 0) begin
        n_tot++; n_bad++;
        $display("FAIL R2 unexpected read data actual=%0h expected=none", reg_rdata);
      end else begin
        chk(32'(reg_rdata), 32'(exp_q.pop_front()), tag_q.pop_front());
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string tag);
    @(negedge clk); reg_rd = 1'b1; reg_addr = AW'(a);
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic rd_st(input logic [7:0] flags, input string tag);
    rd(4'h0, flags | (own_m ? 8'h40 : 8'h00), tag);
    own_m = 1'b1;
  endtask

  task automatic wr_st(input logic [7:0] d);
    wr(4'h0, d);
    if (d[6]) own_m = 1'b0;
  endtask

  task automatic p_done;
    @(negedge clk); eng_done = 1'b1;
    @(negedge clk); eng_done = 1'b0;
  endtask

  task automatic p_err(input logic [1:0] e);
    @(negedge clk); eng_err = e;
    @(negedge clk); eng_err = 2'b00;
  endtask

  task automatic p_byte;
    @(negedge clk); eng_byte = 1'b1;
    @(negedge clk); eng_byte = 1'b0;
  endtask

  task automatic eng_put(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); eng_wr = 1'b1; eng_wr_sel = s; eng_wr_data = d;
    @(negedge clk); eng_wr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tot++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(32'(eng_start), 0, "R1 eng_start");
    chk(32'(irq), 0, "R1 irq");
    chk(32'(eng_hold), 0, "R1 eng_hold");
    rd_st(8'h00, "R1 status after reset");
    // R3 semaphore
    rd_st(8'h00, "R3 second read sees in-use");
    wr_st(8'h40);
    rd_st(8'h00, "R3 released then reclaimed");
    // R2 map
    wr(4'h3, 8'h5A); wr(4'h4, 8'hA7); wr(4'h5, 8'h11); wr(4'h6, 8'h22);
    wr(4'h7, 8'h9C); wr(4'h8, 8'h33); wr(4'h1, 8'h44);
    rd(4'h3, 8'h5A, "R2 command"); rd(4'h4, 8'hA7, "R2 target");
    rd(4'h5, 8'h11, "R2 data0");   rd(4'h6, 8'h22, "R2 data1");
    rd(4'h7, 8'h9C, "R2 block");   rd(4'h8, 8'h00, "R2 reserved 8");
    rd(4'h1, 8'h00, "R2 reserved 1"); rd(4'hF, 8'h00, "R2 reserved F");
    chk(32'(eng_cmd), 32'h5A, "R2 eng_cmd");
    chk(32'(eng_tgt), 32'hA7, "R2 eng_tgt");
    // R5 control readback without go
    wr(4'h2, 8'h15);
    rd(4'h2, 8'h15, "R5 control readback");
    chk(32'(eng_proto), 5, "R5 eng_proto");
    // R9 events while idle
    p_done; p_err(2'b11); p_byte;
    rd_st(8'h00, "R9 idle events ignored");
    chk(32'(irq), 0, "R9 irq idle");
    chk(32'(eng_hold), 0, "R9 hold idle");
    // R5 start
    wr(4'h2, 8'h48);
    chk(32'(eng_start), 1, "R5 start pulse");
    @(negedge clk);
    chk(32'(eng_start), 0, "R5 start one cycle");
    rd_st(8'h01, "R5 busy");
    rd(4'h2, 8'h08, "R5 go reads 0");
    // R6 go while busy
    wr(4'h2, 8'h5D);
    chk(32'(eng_start), 0, "R6 no pulse");
    rd(4'h2, 8'h08, "R6 fields kept");
    chk(32'(eng_proto), 2, "R6 eng_proto kept");
    // R8 done
    p_done;
    rd_st(8'h02, "R8 done clears busy");
    // R4 w1c keeps in-use
    wr_st(8'hBF);
    rd_st(8'h00, "R4 clear all but in-use");
    // R11 irq
    wr(4'h2, 8'h41);
    p_done;
    @(negedge clk);
    chk(32'(irq), 1, "R11 irq raised");
    wr_st(8'hBF);
    @(negedge clk);
    chk(32'(irq), 0, "R11 irq dropped");
    // R7 kill while busy
    wr(4'h2, 8'h48);
    wr(4'h2, 8'h02);
    chk(32'(eng_kill), 1, "R7 kill pulse");
    rd_st(8'h10, "R7 failed and not busy");
    wr_st(8'hFF);
    rd_st(8'h00, "R4 clear everything");
    // R7 kill while idle
    wr(4'h2, 8'h02);
    rd_st(8'h00, "R7 idle kill no fail");
    // R8 errors
    wr(4'h2, 8'h48);
    p_err(2'b01);
    rd_st(8'h04, "R8 device error");
    wr(4'h2, 8'h48);
    p_err(2'b10);
    rd_st(8'h0C, "R8 bus error");
    wr_st(8'h08);
    rd_st(8'h04, "R4 single bit clear");
    wr_st(8'hBF);
    // R12 + R10 block
    wr(4'hC, 8'h01);
    rd(4'hC, 8'h01, "R2 mode");
    wr(4'h2, 8'h54);
    chk(32'(eng_i2c), 1, "R12 i2c on block");
    p_byte;
    chk(32'(eng_hold), 1, "R10 hold set");
    repeat (3) @(negedge clk);
    chk(32'(eng_hold), 1, "R10 hold held");
    rd_st(8'h81, "R10 byte done flag");
    wr_st(8'h80);
    chk(32'(eng_hold), 0, "R10 hold released");
    p_done;
    rd_st(8'h02, "R8 block done");
    wr_st(8'hFF);
    wr(4'h2, 8'h08);
    chk(32'(eng_i2c), 0, "R12 i2c off for non-block");
    // R13 engine writes
    eng_put(2'd0, 8'h77); eng_put(2'd1, 8'h88); eng_put(2'd2, 8'h99);
    rd(4'h5, 8'h77, "R13 data0"); rd(4'h6, 8'h88, "R13 data1");
    rd(4'h7, 8'h99, "R13 block");
    chk(32'(eng_d0), 32'h77, "R13 eng_d0");
    repeat (3) @(negedge clk);
    chk(32'(exp_q.size()), 0, "R2 all reads answered");
    $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
    $finish;
  end
endmodule